// File: doc/BRIEF.md
# Shifted-Operand Subtract Unit with Condition Flags

This block decodes one 32-bit instruction word of the form "subtract a shifted register from a register and set the flags" and executes it. It exposes two combinational read-index outputs to an external general register file, takes the two read values back in the same cycle, and one clock edge later presents the destination index, a write strobe, the result and an undefined-instruction flag. It also holds the four-bit N/Z/C/V condition register.

The second operand is shifted left logically, right logically or right arithmetically by an amount taken from the instruction. The shifted value is inverted and added to the first operand with a carry-in of one. Both a 32-bit and a 64-bit form are supported. Index 31 reads as zero and is never written, so the compare form (destination 31) and the negate form (first source 31) need no special handling.

Top module: `shsub_unit`

## Requirements
- R1: While reset is held and after it is released, `resValid`, `wrEn` and `undef` are 0 and `nzcv` is 0000 until the first accepted instruction.
- R2: Instruction fields are: bit 31 size (0 = 32-bit, 1 = 64-bit), bits 30..24 must equal 1101011, bit 21 must be 0, bits 23..22 shift kind, bits 20..16 second source, bits 15..10 shift amount, bits 9..5 first source, bits 4..0 destination. A word whose bits 30..24 or bit 21 differ is reported as undefined.
- R3: One clock edge after `instrValid` is high, `resValid` is 1, `wrIdx` equals the destination field and `wrData` equals first source minus the shifted second source.
- R4: Shift kind 00 shifts left, 01 shifts right filling zeros, 10 shifts right copying the sign bit of the selected width; an amount of 0 leaves the operand unchanged.
- R5: Shift kind 11 is reported as undefined.
- R6: In 32-bit form, an amount with bit 5 set is reported as undefined; in 64-bit form amounts 0 to 63 are all valid.
- R7: In 32-bit form only the low 32 bits of each source are used, the result is zero-extended to 64 bits, and the flags describe the 32-bit result.
- R8: After a defined instruction, `nzcv[3]` (N) is the result's sign bit, `nzcv[2]` (Z) is 1 when the result is zero, `nzcv[1]` (C) is 1 when no borrow occurs (unsigned first source >= shifted operand), and `nzcv[0]` (V) is 1 on signed overflow of the subtraction.
- R9: A source index of 31 supplies zero regardless of the read data; a destination of 31 gives `wrEn` = 0 while the flags still update.
- R10: When `undef` is reported, `wrEn` is 0 and `nzcv` keeps its previous value.
- R11: In a cycle after which `instrValid` was low, `resValid` and `wrEn` are 0 and `nzcv` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rnIdx | output | 5 | First-source read index (combinational from `instr`) |
| rmIdx | output | 5 | Second-source read index (combinational from `instr`) |
| rnData | input | 64 | Register file value at `rnIdx`, same cycle |
| rmData | input | 64 | Register file value at `rmIdx`, same cycle |
| resValid | output | 1 | Registered: an instruction was executed on the last edge |
| undef | output | 1 | Registered: that instruction was undefined |
| wrEn | output | 1 | Registered write strobe for the register file |
| wrIdx | output | 5 | Registered destination index |
| wrData | output | 64 | Registered result value |
| nzcv | output | 4 | Condition register, N in bit 3 down to V in bit 0 |

## Verification
The read indices follow the instruction word in the same cycle, and every other result (`resValid`, `undef`, `wrEn`, `wrIdx`, `wrData` and the new `nzcv`) is due exactly one rising edge after the edge that sampled `instrValid`. The driver applies each word on a falling edge and queues the expected outcome. The monitor inspects outputs on every following falling edge, so each queued item is compared half a period after the edge that produced it. A `resValid` with nothing queued, and any change of `nzcv` across idle cycles, is counted as a failure.

// File: rtl/shsub_pkg.sv
package shsub_pkg;

  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int AMT_W   = 6;
  localparam int OPC_W   = 7;

  localparam int SIZE_POS  = 31;
  localparam int OPC_LO    = 24;
  localparam int KIND_LO   = 22;
  localparam int GAP_POS   = 21;
  localparam int RM_LO     = 16;
  localparam int AMT_LO    = 10;
  localparam int RN_LO     = 5;
  localparam int RD_LO     = 0;

  localparam logic [OPC_W-1:0] OPC_SUB_FLAGS = 7'b1101011;
  localparam logic [IDX_W-1:0] ZERO_IDX      = 5'd31;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_ARITH = 2'b10,
    SH_RSVD  = 2'b11
  } shift_e;

  typedef struct packed {
    logic             issue;
    logic             commit;
    logic             undef;
    logic             wide;
    shift_e           kind;
    logic [AMT_W-1:0] amt;
    logic             rnZero;
    logic             rmZero;
    logic             wrReg;
  } ctrl_t;

endpackage

// File: rtl/shsub_ctrl.sv
module shsub_ctrl
  import shsub_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   rnIdx,
  output logic [IDX_W-1:0]   rmIdx,
  output logic [IDX_W-1:0]   rdIdx,
  output ctrl_t              ctrl
);

  logic             sizeBit;
  logic [1:0]       kindCode;
  logic [OPC_W-1:0] opField;
  logic             gapBit;
  logic [AMT_W-1:0] amtField;
  logic             badPattern;
  logic             rsvdKind;
  logic             badAmount;
  logic             isUndef;

  always_comb begin
    sizeBit  = instr[SIZE_POS];
    kindCode = instr[KIND_LO +: 2];
    opField  = instr[OPC_LO +: OPC_W];
    gapBit   = instr[GAP_POS];
    amtField = instr[AMT_LO +: AMT_W];
    rmIdx    = instr[RM_LO +: IDX_W];
    rnIdx    = instr[RN_LO +: IDX_W];
    rdIdx    = instr[RD_LO +: IDX_W];
  end

  always_comb begin
    badPattern = (opField != OPC_SUB_FLAGS) || gapBit;
    rsvdKind   = (kindCode == SH_RSVD);
    badAmount  = !sizeBit && amtField[AMT_W-1];
    isUndef    = badPattern || rsvdKind || badAmount;
  end

  always_comb begin
    ctrl.issue  = instrValid;
    ctrl.commit = instrValid && !isUndef;
    ctrl.undef  = isUndef;
    ctrl.wide   = sizeBit;
    ctrl.kind   = shift_e'(kindCode);
    ctrl.amt    = amtField;
    ctrl.rnZero = (rnIdx == ZERO_IDX);
    ctrl.rmZero = (rmIdx == ZERO_IDX);
    ctrl.wrReg  = (rdIdx != ZERO_IDX);
  end

endmodule

// File: rtl/shsub_shift.sv
module shsub_shift
  import shsub_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             wide,
  input  shift_e           kind,
  input  logic [AMT_W-1:0] amt,
  input  logic [XLEN-1:0]  opnd,
  output logic [XLEN-1:0]  shifted
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] raw;
  logic [SHW-1:0]  shamt;
  logic            fillBit;

  // Narrow form: the upper half carries the sign only for the arithmetic kind,
  // so one full-width shifter serves both sizes.
  always_comb begin
    fillBit = (kind == SH_ARITH) && opnd[HALF-1];
    src     = wide ? opnd : {{HALF{fillBit}}, opnd[HALF-1:0]};
    shamt   = wide ? amt[SHW-1:0] : {1'b0, amt[SHW-2:0]};
  end

  always_comb begin
    unique case (kind)
      SH_LEFT:  raw = src << shamt;
      SH_RIGHT: raw = src >> shamt;
      SH_ARITH: raw = $unsigned($signed(src) >>> shamt);
      default:  raw = src;
    endcase
    shifted = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
  end

endmodule

// File: rtl/shsub_dp.sv
module shsub_dp
  import shsub_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [XLEN-1:0]  rnData,
  input  logic [XLEN-1:0]  rmData,
  output logic             resValid,
  output logic             undef,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrIdx,
  output logic [XLEN-1:0]  wrData,
  output logic [3:0]       nzcv
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] opA;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] shiftedB;
  logic [XLEN-1:0] invB;
  logic [XLEN:0]   sumWide;
  logic [HALF:0]   sumNarrow;
  logic [XLEN-1:0] result;
  logic            aTop;
  logic            bTop;
  logic            rTop;
  logic            carryOut;
  logic [3:0]      newFlags;

  always_comb begin
    opA = ctrl.rnZero ? '0 : rnData;
    opB = ctrl.rmZero ? '0 : rmData;
  end

  shsub_shift #(.XLEN(XLEN)) u_shift (
    .wide    (ctrl.wide),
    .kind    (ctrl.kind),
    .amt     (ctrl.amt),
    .opnd    (opB),
    .shifted (shiftedB)
  );

  // Subtraction as addition of the inverted operand with a carry-in of one;
  // a separate narrow adder supplies the 32-bit carry out.
  always_comb begin
    invB      = ~shiftedB;
    sumWide   = {1'b0, opA} + {1'b0, invB} + (XLEN+1)'(1);
    sumNarrow = {1'b0, opA[HALF-1:0]} + {1'b0, invB[HALF-1:0]} + (HALF+1)'(1);
  end

  always_comb begin
    if (ctrl.wide) begin
      result   = sumWide[XLEN-1:0];
      carryOut = sumWide[XLEN];
      aTop     = opA[XLEN-1];
      bTop     = invB[XLEN-1];
      rTop     = sumWide[XLEN-1];
    end else begin
      result   = {{HALF{1'b0}}, sumNarrow[HALF-1:0]};
      carryOut = sumNarrow[HALF];
      aTop     = opA[HALF-1];
      bTop     = invB[HALF-1];
      rTop     = sumNarrow[HALF-1];
    end
    newFlags = {rTop, (result == '0), carryOut, (aTop == bTop) && (rTop != aTop)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      undef    <= 1'b0;
      wrEn     <= 1'b0;
      wrIdx    <= '0;
      wrData   <= '0;
      nzcv     <= '0;
    end else begin
      resValid <= ctrl.issue;
      undef    <= ctrl.issue && ctrl.undef;
      wrEn     <= ctrl.commit && ctrl.wrReg;
      if (ctrl.issue) begin
        wrIdx  <= rdIdx;
        wrData <= result;
      end
      if (ctrl.commit) begin
        nzcv   <= newFlags;
      end
    end
  end

endmodule

// File: rtl/shsub_unit.sv
module shsub_unit
  import shsub_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [31:0]      instr,
  output logic [4:0]       rnIdx,
  output logic [4:0]       rmIdx,
  input  logic [XLEN-1:0]  rnData,
  input  logic [XLEN-1:0]  rmData,
  output logic             resValid,
  output logic             undef,
  output logic             wrEn,
  output logic [4:0]       wrIdx,
  output logic [XLEN-1:0]  wrData,
  output logic [3:0]       nzcv
);

  ctrl_t            ctrl;
  logic [IDX_W-1:0] rdIdx;

  shsub_ctrl u_ctrl (
    .instrValid (instrValid),
    .instr      (instr),
    .rnIdx      (rnIdx),
    .rmIdx      (rmIdx),
    .rdIdx      (rdIdx),
    .ctrl       (ctrl)
  );

  shsub_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .rdIdx    (rdIdx),
    .rnData   (rnData),
    .rmData   (rmData),
    .resValid (resValid),
    .undef    (undef),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .nzcv     (nzcv)
  );

endmodule

// File: rtl/shsub_chk.sv
module shsub_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic [31:0]     instr,
  input logic            resValid,
  input logic            undef,
  input logic            wrEn,
  input logic [4:0]      wrIdx,
  input logic [XLEN-1:0] wrData,
  input logic [3:0]      nzcv
);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(instrValid) |-> (!resValid && !wrEn));

  p_idle_flags_r11: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(nzcv));

  p_undef_nowrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> (resValid && !wrEn));

  p_undef_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> $stable(nzcv));

  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrIdx != 5'd31));

  p_zext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !$past(instr[31])) |-> (wrData[XLEN-1:XLEN/2] == '0));

  p_zflag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !undef) |-> (nzcv[2] == (wrData == '0)));

  p_nflag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !undef && $past(instr[31])) |-> (nzcv[3] == wrData[XLEN-1]));

endmodule

bind shsub_unit shsub_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instr      (instr),
  .resValid   (resValid),
  .undef      (undef),
  .wrEn       (wrEn),
  .wrIdx      (wrIdx),
  .wrData     (wrData),
  .nzcv       (nzcv)
);

// File: tb/sim_shsub_unit.sv
`timescale 1ns/1ps
module sim_shsub_unit;

  localparam int XLEN = 64;
  localparam logic [63:0] JUNK = 64'hA5A5_5A5A_F0F0_0F0F;

  typedef struct {
    logic        undef;
    logic        wrEn;
    logic [4:0]  wrIdx;
    logic [63:0] wrData;
    logic [3:0]  nzcv;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  rnIdx, rmIdx, wrIdx;
  logic [63:0] rnData, rmData, wrData;
  logic        resValid, undef, wrEn;
  logic [3:0]  nzcv;

  logic [63:0] rf [0:30];
  logic [3:0]  modelFlags = '0;
  item_t       expQ[$];
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign rnData = (rnIdx == 5'd31) ? JUNK : rf[rnIdx];
  assign rmData = (rmIdx == 5'd31) ? ~JUNK : rf[rmIdx];

  shsub_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .rnIdx(rnIdx), .rmIdx(rmIdx), .rnData(rnData), .rmData(rmData),
    .resValid(resValid), .undef(undef), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .nzcv(nzcv)
  );

  function automatic logic [31:0] enc(logic sf, logic [1:0] kind, logic [4:0] rm,
                                      logic [5:0] amt, logic [4:0] rn, logic [4:0] rd);
    return {sf, 7'b1101011, kind, 1'b0, rm, amt, rn, rd};
  endfunction

  function automatic item_t model(logic [31:0] w, string tag);
    item_t it;
    logic sf = w[31];
    logic [1:0] kind = w[23:22];
    logic [4:0] rm = w[20:16], rn = w[9:5], rd = w[4:0];
    logic [5:0] amt = w[15:10];
    logic [63:0] a, b, op, res;
    logic [31:0] a32, b32, op32, res32;
    it.tag = tag;
    it.wrIdx = rd;
    it.wrData = '0;
    if (w[30:24] != 7'b1101011 || w[21] || kind == 2'b11 || (!sf && amt[5])) begin
      it.undef = 1'b1;
      it.wrEn = 1'b0;
      it.nzcv = modelFlags;
      return it;
    end
    a = (rn == 5'd31) ? 64'd0 : rf[rn];
    b = (rm == 5'd31) ? 64'd0 : rf[rm];
    it.undef = 1'b0;
    it.wrEn = (rd != 5'd31);
    if (sf) begin
      case (kind)
        2'b00:   op = b << amt;
        2'b01:   op = b >> amt;
        default: op = $unsigned($signed(b) >>> amt);
      endcase
      res = a - op;
      it.wrData = res;
      it.nzcv = {res[63], res == 0, a >= op, (a[63] != op[63]) && (res[63] != a[63])};
    end else begin
      a32 = a[31:0];
      b32 = b[31:0];
      case (kind)
        2'b00:   op32 = b32 << amt[4:0];
        2'b01:   op32 = b32 >> amt[4:0];
        default: op32 = $unsigned($signed(b32) >>> amt[4:0]);
      endcase
      res32 = a32 - op32;
      it.wrData = {32'd0, res32};
      it.nzcv = {res32[31], res32 == 0, a32 >= op32,
                 (a32[31] != op32[31]) && (res32[31] != a32[31])};
    end
    return it;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w, string tag);
    item_t it;
    @(negedge clk);
    it = model(w, tag);
    if (!it.undef) modelFlags = it.nzcv;
    expQ.push_back(it);
    instr = w;
    instrValid = 1'b1;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    instrValid = 1'b0;
    instr = 32'hFFFF_FFFF;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: results are due one rising edge after the sampling edge.
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected resValid", 64'd1, 64'd0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(undef == e.undef && wrEn == e.wrEn && wrIdx == e.wrIdx && nzcv == e.nzcv &&
              (e.undef || wrData == e.wrData), e.tag, "undef/wrEn/wrIdx/nzcv/wrData",
              {undef, wrEn, 2'b0, nzcv, 3'b0, wrIdx, wrData[47:0]},
              {e.undef, e.wrEn, 2'b0, e.nzcv, 3'b0, e.wrIdx, e.wrData[47:0]});
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 31; i++) rf[i] = 64'h0123_4567_89AB_CDEF * (i + 3) ^ (64'd1 << (i * 2));
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    check(!resValid && !wrEn && !undef && nzcv == 4'b0, "R1", "reset outputs",
          {resValid, wrEn, undef, nzcv}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!resValid && !wrEn && !undef && nzcv == 4'b0, "R1", "after release",
          {resValid, wrEn, undef, nzcv}, 64'd0);

    rf[1] = 64'd100; rf[2] = 64'd30; rf[3] = 64'h8000_0000_0000_0000; rf[4] = 64'd1;
    rf[5] = 64'hF000_0000_0000_0010; rf[6] = 64'hFFFF_FFFF_8000_0000; rf[7] = 64'h1234_5678_0000_0001;
    send(enc(1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd9),  "R3 basic 64-bit amount 0");
    send(enc(1, 2'b00, 5'd1, 6'd0, 5'd1, 5'd10), "R8 equal gives Z");
    send(enc(1, 2'b00, 5'd1, 6'd0, 5'd2, 5'd11), "R8 borrow gives N, C=0");
    send(enc(1, 2'b00, 5'd4, 6'd0, 5'd3, 5'd12), "R8 signed overflow V");
    send(enc(1, 2'b00, 5'd4, 6'd63, 5'd1, 5'd13), "R4 shift left 63");
    send(enc(1, 2'b01, 5'd5, 6'd4, 5'd1, 5'd14), "R4 shift right zero fill");
    send(enc(1, 2'b10, 5'd5, 6'd4, 5'd1, 5'd15), "R4 shift right sign fill 64");
    send(enc(0, 2'b10, 5'd6, 6'd31, 5'd7, 5'd16), "R7 32-bit sign fill from bit 31");
    send(enc(0, 2'b01, 5'd6, 6'd4, 5'd5, 5'd17), "R7 32-bit zero-extend, upper ignored");
    send(enc(0, 2'b00, 5'd4, 6'd31, 5'd4, 5'd18), "R7 32-bit flags on 32 bits");
    send(enc(1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd31), "R9 compare form no write");
    send(enc(1, 2'b00, 5'd2, 6'd0, 5'd31, 5'd19), "R9 negate form reads zero");
    send(enc(0, 2'b00, 5'd31, 6'd0, 5'd7, 5'd20), "R9 second source reads zero");
    send(enc(1, 2'b11, 5'd2, 6'd0, 5'd1, 5'd21), "R5 reserved kind undefined, R10 hold");
    send(enc(0, 2'b00, 5'd2, 6'd32, 5'd1, 5'd22), "R6 32-bit amount 32 undefined");
    send(enc(1, 2'b00, 5'd2, 6'd32, 5'd1, 5'd23), "R6 64-bit amount 32 valid");
    send(enc(1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd24) ^ 32'h0100_0000, "R2 bad opcode bits undefined");
    send(enc(1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd25) | 32'h0020_0000, "R2 bit 21 set undefined");
    idle(4);
    // R11: flags and strobes quiet with no instruction
    check(!resValid && !wrEn && nzcv == modelFlags, "R11", "idle hold",
          {resValid, wrEn, nzcv}, {2'b00, modelFlags});

    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] kd;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      kd = (lfsr[23:22] == 2'b11) ? 2'b10 : lfsr[23:22];
      send(enc(lfsr[31], kd, lfsr[20:16], {lfsr[31] & lfsr[15], lfsr[14:10]},
               lfsr[9:5], lfsr[4:0]), "R3 mixed pattern");
    end
    idle(3);
    check(expQ.size() == 0, "R3", "all results produced", expQ.size(), 64'd0);
    done = 1;
    finishRun();
  end

endmodule